// File: doc/BRIEF.md
# Indirect Command Mailbox Responder

This block is the device side of a command mailbox that a host reaches through two configuration-space words. One word, the index, holds a target address. The other, the data window, reads or writes whatever mailbox register that index selects. Behind the window sit a message-number register, a one-byte status register and eight 32-bit argument registers.

The host loads the arguments first, optionally clears the status, and then writes the message number. That write starts a small built-in command engine. Completion time is modelled by a programmable minimum latency followed by alignment to a free-running service tick. Status reads as not-ready while the command is pending. On completion the engine sets a status code and writes its response words over the argument registers, starting at argument 0.

The engine knows three commands: an increment test, a version query, and a query that returns a 64-bit table address selected by argument 0.

Top module: `mbx_responder`

## Requirements
- R1: After reset, the index, the message-number register, the status register and all argument registers read as zero.
- R2: A configuration write at offset 0xC4 loads the index, and a read at 0xC4 returns it. Accesses at 0xC8 read or write the register the index selects. Any other configuration offset reads zero.
- R3: The index value BASE+ARG_OFF+4*i selects argument i (i from 0 to 7). Index values that map to no mailbox register, including unaligned ones, read zero, and writes to them change no register.
- R4: Writing the message-number register (index BASE+ID_OFF) while idle starts a command, and status reads 0x00 until the command completes. Completion falls on a service tick, between LAT+1 and LAT+PERIOD clock edges after the starting write, and the delay is the same for starts that share the same tick phase.
- R5: Command 1 (test) writes argument 0 plus one (modulo 2^32) into argument 0, leaves argument 1 alone, and sets status 0x01.
- R6: Command 2 (version) writes the VERSION parameter into argument 0 and sets status 0x01.
- R7: Command 3 (address) with argument 0 below NTBL writes TBL_BASE + arg0*TBL_STRIDE as a 64-bit value: the low word into argument 0 and the high word into argument 1. Status becomes 0x01.
- R8: Command numbers 0, 4 (reserved) and anything of 5 or above set status 0xFE and leave the arguments untouched.
- R9: Command 3 with argument 0 at or above NTBL sets status 0xFF and leaves the arguments untouched.
- R10: A message-number write while a command is pending is ignored. The register keeps the first number, and the result is that of the first command.
- R11: A host write to the status register stores the low byte of the written data. Writing 0x00 clears it.
- R12: In the clock edge where a command completes, a host write through the data window is dropped. The engine's status and response words win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_off | input | 8 | Configuration offset (0xC4 index, 0xC8 data window) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_off |

## Verification
The engine's write-back and a host write through the data window can land on the same clock edge. The first run of a command measures its completion delay. A second run is then started at the same phase of the service tick, so the completion edge can be predicted, and the host write is aimed at that edge. The bench writes argument 0 in one such run and clears the status in another. In both cases it judges the outcome by reading back the engine's response and the 0x01 status rather than the host's value. The replay also confirms that the completion delay repeats for the same tick phase.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam logic [7:0] ST_PEND   = 8'h00;
   localparam logic [7:0] ST_OK     = 8'h01;
   localparam logic [7:0] ST_BADMSG = 8'hFE;
   localparam logic [7:0] ST_BADIN  = 8'hFF;

   localparam logic [31:0] CMD_TEST = 32'd1;
   localparam logic [31:0] CMD_VER  = 32'd2;
   localparam logic [31:0] CMD_ADDR = 32'd3;
   localparam logic [31:0] CMD_RSVD = 32'd4;

   typedef logic [31:0] word_t;
endpackage

// File: rtl/mbx_tick.sv
module mbx_tick #(
   parameter int PERIOD = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (PERIOD == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int TW = $clog2(PERIOD);
         localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);
         logic [TW-1:0] tcnt;
         always_ff @(posedge clk) begin
            if (!rst_n)          tcnt <= '0;
            else if (tcnt == LAST) tcnt <= '0;
            else                 tcnt <= tcnt + 1'b1;
         end
         assign tick = (tcnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode #(
   parameter logic [31:0] BASE    = 32'h0004_0000,
   parameter logic [31:0] ID_OFF  = 32'h34,
   parameter logic [31:0] ST_OFF  = 32'h80,
   parameter logic [31:0] ARG_OFF = 32'hE0,
   parameter int          NARG    = 8,
   localparam int         SW      = $clog2(NARG)
) (
   input  logic [31:0]   idx,
   output logic          hit_id,
   output logic          hit_st,
   output logic          hit_arg,
   output logic [SW-1:0] arg_sel
);
   logic [NARG-1:0] match;

   generate
      for (genvar i = 0; i < NARG; i++) begin : g_arg
         localparam logic [31:0] A_I = BASE + ARG_OFF + 32'(4 * i);
         assign match[i] = (idx == A_I);
      end
   endgenerate

   assign hit_id  = (idx == BASE + ID_OFF);
   assign hit_st  = (idx == BASE + ST_OFF);
   assign hit_arg = |match;

   always_comb begin
      arg_sel = '0;
      for (int i = 0; i < NARG; i++) begin
         if (match[i]) arg_sel = SW'(i);
      end
   end
endmodule

// File: rtl/mbx_eval.sv
module mbx_eval
   import mbx_pkg::*;
#(
   parameter int          NARG       = 8,
   parameter logic [31:0] VERSION    = 32'h0006_0002,
   parameter logic [63:0] TBL_BASE   = 64'h0000_00A5_4000_0000,
   parameter logic [63:0] TBL_STRIDE = 64'h1000,
   parameter int          NTBL       = 2
) (
   input  word_t                  cmd,
   input  word_t                  arg0,
   output logic [7:0]             code,
   output logic [NARG-1:0]        mask,
   output logic [NARG-1:0][31:0]  data
);
   logic [63:0] addr;

   assign addr = TBL_BASE + ({32'd0, arg0} * TBL_STRIDE);

   always_comb begin
      code = ST_BADMSG;
      mask = '0;
      data = '0;
      case (cmd)
         CMD_TEST: begin
            code    = ST_OK;
            mask[0] = 1'b1;
            data[0] = arg0 + 32'd1;
         end
         CMD_VER: begin
            code    = ST_OK;
            mask[0] = 1'b1;
            data[0] = VERSION;
         end
         CMD_ADDR: begin
            if (arg0 < 32'(NTBL)) begin
               code    = ST_OK;
               mask[1:0] = 2'b11;
               data[0] = addr[31:0];
               data[1] = addr[63:32];
            end else begin
               code = ST_BADIN;
            end
         end
         default: code = ST_BADMSG;
      endcase
   end
endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
   import mbx_pkg::*;
#(
   parameter int          LAT        = 5,
   parameter int          NARG       = 8,
   parameter logic [31:0] VERSION    = 32'h0006_0002,
   parameter logic [63:0] TBL_BASE   = 64'h0000_00A5_4000_0000,
   parameter logic [63:0] TBL_STRIDE = 64'h1000,
   parameter int          NTBL       = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  start,
   input  word_t                 start_id,
   input  word_t                 start_arg0,
   output logic                  busy,
   output logic                  done,
   output logic [7:0]            code,
   output logic [NARG-1:0]       wr_mask,
   output logic [NARG-1:0][31:0] wr_data
);
   localparam int CW = $clog2(LAT + 1);
   localparam logic [CW-1:0] LAT_V = CW'(LAT);

   logic [CW-1:0] cnt;
   word_t         cmd_q;
   word_t         arg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt   <= '0;
         cmd_q <= '0;
         arg_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         cnt   <= LAT_V;
         cmd_q <= start_id;
         arg_q <= start_arg0;
      end else if (done) begin
         busy  <= 1'b0;
      end else if (busy && cnt != '0) begin
         cnt   <= cnt - 1'b1;
      end
   end

   assign done = busy && (cnt == '0) && tick;

   mbx_eval #(
      .NARG(NARG), .VERSION(VERSION), .TBL_BASE(TBL_BASE),
      .TBL_STRIDE(TBL_STRIDE), .NTBL(NTBL)
   ) u_eval (
      .cmd(cmd_q), .arg0(arg_q), .code(code), .mask(wr_mask), .data(wr_data)
   );
endmodule

// File: rtl/mbx_responder.sv
module mbx_responder
   import mbx_pkg::*;
#(
   parameter logic [31:0] BASE       = 32'h0004_0000,
   parameter logic [31:0] ID_OFF     = 32'h34,
   parameter logic [31:0] ST_OFF     = 32'h80,
   parameter logic [31:0] ARG_OFF    = 32'hE0,
   parameter int          NARG       = 8,
   parameter int          LAT        = 5,
   parameter int          PERIOD     = 8,
   parameter logic [31:0] VERSION    = 32'h0006_0002,
   parameter logic [63:0] TBL_BASE   = 64'h0000_00A5_4000_0000,
   parameter logic [63:0] TBL_STRIDE = 64'h1000,
   parameter int          NTBL       = 2,
   parameter logic [7:0]  IDX_CFG    = 8'hC4,
   parameter logic [7:0]  DATA_CFG   = 8'hC8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [7:0]  cfg_off,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata
);
   localparam int SW = $clog2(NARG);

   initial begin
      if (NARG < 2 || NARG > 64) $fatal(1, "NARG out of range");
      if (LAT < 1)               $fatal(1, "LAT must be at least 1");
      if (PERIOD < 1)            $fatal(1, "PERIOD must be at least 1");
      if (NTBL < 1)              $fatal(1, "NTBL must be at least 1");
   end

   word_t                  idx;
   word_t                  msg_id;
   logic [7:0]             stat;
   logic [NARG-1:0][31:0]  args;

   logic                   hit_id, hit_st, hit_arg;
   logic [SW-1:0]          arg_sel;
   logic                   tick, busy, done;
   logic [7:0]             eng_code;
   logic [NARG-1:0]        wr_mask;
   logic [NARG-1:0][31:0]  wr_data;

   logic                   data_wr, host_ok, id_wr, start;

   assign data_wr = cfg_wr && (cfg_off == DATA_CFG);
   assign host_ok = data_wr && !done;
   assign id_wr   = data_wr && hit_id;
   assign start   = id_wr && !busy && !done;

   mbx_decode #(
      .BASE(BASE), .ID_OFF(ID_OFF), .ST_OFF(ST_OFF),
      .ARG_OFF(ARG_OFF), .NARG(NARG)
   ) u_dec (
      .idx(idx), .hit_id(hit_id), .hit_st(hit_st),
      .hit_arg(hit_arg), .arg_sel(arg_sel)
   );

   mbx_tick #(.PERIOD(PERIOD)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   mbx_engine #(
      .LAT(LAT), .NARG(NARG), .VERSION(VERSION), .TBL_BASE(TBL_BASE),
      .TBL_STRIDE(TBL_STRIDE), .NTBL(NTBL)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
      .start_id(cfg_wdata), .start_arg0(args[0]),
      .busy(busy), .done(done), .code(eng_code),
      .wr_mask(wr_mask), .wr_data(wr_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                              idx <= '0;
      else if (cfg_wr && cfg_off == IDX_CFG)   idx <= cfg_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     msg_id <= '0;
      else if (start) msg_id <= cfg_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  stat <= ST_PEND;
      else if (start)              stat <= ST_PEND;
      else if (done)               stat <= eng_code;
      else if (host_ok && hit_st)  stat <= cfg_wdata[7:0];
   end

   generate
      for (genvar i = 0; i < NARG; i++) begin : g_argreg
         always_ff @(posedge clk) begin
            if (!rst_n)
               args[i] <= '0;
            else if (done && wr_mask[i])
               args[i] <= wr_data[i];
            else if (host_ok && hit_arg && arg_sel == SW'(i))
               args[i] <= cfg_wdata;
         end
      end
   endgenerate

   always_comb begin
      cfg_rdata = '0;
      if (cfg_off == IDX_CFG) begin
         cfg_rdata = idx;
      end else if (cfg_off == DATA_CFG) begin
         if (hit_id)       cfg_rdata = msg_id;
         else if (hit_st)  cfg_rdata = busy ? 32'd0 : {24'd0, stat};
         else if (hit_arg) cfg_rdata = args[arg_sel];
      end
   end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
   import mbx_pkg::*;
#(
   parameter int NARG   = 8,
   parameter int LAT    = 5,
   parameter int PERIOD = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  busy,
   input logic                  done,
   input logic                  tick,
   input logic                  start,
   input logic                  id_wr,
   input logic [31:0]           msg_id,
   input logic [7:0]            stat,
   input logic [7:0]            eng_code,
   input logic [NARG-1:0][31:0] args
);
   logic [15:0] wcnt;

   always_ff @(posedge clk) begin
      if (!rst_n)    wcnt <= '0;
      else if (busy) wcnt <= wcnt + 16'd1;
      else           wcnt <= '0;
   end

   a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (32'(wcnt) >= LAT && 32'(wcnt) <= LAT + PERIOD - 1));

   a_r4_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (tick && busy));

   a_r4_start_pending: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && stat == ST_PEND));

   a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && id_wr) |=> $stable(msg_id));

   a_r8_args_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (eng_code == ST_BADMSG || eng_code == ST_BADIN)) |=> $stable(args));

   a_r12_engine_wins: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (stat == $past(eng_code) && !busy));
endmodule

bind mbx_responder mbx_checker #(.NARG(NARG), .LAT(LAT), .PERIOD(PERIOD)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .tick(tick),
   .start(start), .id_wr(id_wr), .msg_id(msg_id), .stat(stat),
   .eng_code(eng_code), .args(args)
);

// File: tb/test_mbx_responder.sv
module test_mbx_responder;
   localparam logic [31:0] BASE  = 32'h0004_0000;
   localparam logic [31:0] A_ID  = BASE + 32'h34;
   localparam logic [31:0] A_ST  = BASE + 32'h80;
   localparam logic [31:0] A_ARG = BASE + 32'hE0;
   localparam int LAT = 5;
   localparam int PER = 8;
   localparam logic [7:0] C_IDX = 8'hC4;
   localparam logic [7:0] C_DAT = 8'hC8;
   localparam logic [31:0] PRE1 = 32'hC0DE_0000;

   localparam int NV = 9;
   localparam logic [31:0] T_ID [NV] = '{32'd1, 32'd1, 32'd2, 32'd3, 32'd3, 32'd3, 32'd0, 32'd4, 32'd9};
   localparam logic [31:0] T_A0 [NV] = '{32'hDEADBEEF, 32'hFFFFFFFF, 32'd0, 32'd0, 32'd1, 32'd2, 32'd7, 32'd8, 32'd9};
   localparam logic [31:0] T_ST [NV] = '{32'h01, 32'h01, 32'h01, 32'h01, 32'h01, 32'hFF, 32'hFE, 32'hFE, 32'hFE};
   localparam logic [31:0] T_R0 [NV] = '{32'hDEADBEF0, 32'h0, 32'h0006_0002, 32'h4000_0000, 32'h4000_1000, 32'd2, 32'd7, 32'd8, 32'd9};
   localparam logic [31:0] T_R1 [NV] = '{PRE1, PRE1, PRE1, 32'hA5, 32'hA5, PRE1, PRE1, PRE1, PRE1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [7:0] cfg_off = 8'h00;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;

   int nchk = 0;
   int nerr = 0;
   int cyc = 0;
   int last_w = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mbx_responder i_mbx_responder (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_off(cfg_off),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] off, input logic [31:0] d);
      cfg_off = off; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic reg_wr(input logic [31:0] a, input logic [31:0] d);
      cfg_write(C_IDX, a);
      cfg_write(C_DAT, d);
   endtask

   task automatic reg_rd(input logic [31:0] a, output logic [31:0] d);
      cfg_write(C_IDX, a);
      cfg_off = C_DAT;
      #1 d = cfg_rdata;
   endtask

   task automatic wait_status(output int delta);
      int n;
      n = 0;
      cfg_write(C_IDX, A_ST);
      cfg_off = C_DAT;
      #1 check("R4 pending status", cfg_rdata, 32'h0);
      while (cfg_rdata == 32'h0 && n < 200) begin
         @(negedge clk); #1;
         n++;
      end
      delta = cyc - last_w;
   endtask

   task automatic run_cmd(input logic [31:0] id, input logic [31:0] a0, output int delta);
      reg_wr(A_ARG, a0);
      reg_wr(A_ARG + 32'd4, PRE1);
      reg_wr(A_ST, 32'h0);
      cfg_write(C_IDX, A_ID);
      cfg_write(C_DAT, id);
      last_w = cyc;
      wait_status(delta);
      nchk++;
      if (delta < LAT + 1 || delta > LAT + PER) begin
         nerr++;
         $display("FAIL R4 latency: got %0d expected %0d..%0d", delta, LAT + 1, LAT + PER);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int d, d2, w2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      cfg_off = C_IDX; #1 check("R1 index", cfg_rdata, 32'h0);
      reg_rd(A_ST, v);  check("R1 status", v, 32'h0);
      reg_rd(A_ID, v);  check("R1 msg id", v, 32'h0);
      reg_rd(A_ARG, v); check("R1 arg0", v, 32'h0);
      reg_rd(A_ARG + 32'd28, v); check("R1 arg7", v, 32'h0);

      // R2 index and window
      cfg_write(C_IDX, 32'h1234_5678);
      cfg_off = C_IDX; #1 check("R2 index readback", cfg_rdata, 32'h1234_5678);
      cfg_off = 8'hC0; #1 check("R2 other offset", cfg_rdata, 32'h0);

      // R3 arguments and unmapped space
      reg_wr(A_ARG + 32'd28, 32'hA7A7_0007);
      reg_rd(A_ARG + 32'd28, v); check("R3 arg7", v, 32'hA7A7_0007);
      reg_wr(A_ARG + 32'd2, 32'hBAD0_0001);
      reg_rd(A_ARG + 32'd2, v); check("R3 unaligned reads zero", v, 32'h0);
      reg_wr(BASE + 32'h100, 32'hBAD0_0002);
      reg_rd(BASE + 32'h100, v); check("R3 unmapped reads zero", v, 32'h0);
      reg_rd(A_ARG, v); check("R3 arg0 untouched", v, 32'h0);
      reg_rd(A_ARG + 32'd28, v); check("R3 arg7 untouched", v, 32'hA7A7_0007);

      // R11 status host write
      reg_wr(A_ST, 32'h0000_01FE);
      reg_rd(A_ST, v); check("R11 status low byte", v, 32'hFE);
      reg_wr(A_ST, 32'h0);
      reg_rd(A_ST, v); check("R11 status clear", v, 32'h0);

      // R5..R9 command table
      for (int k = 0; k < NV; k++) begin
         run_cmd(T_ID[k], T_A0[k], d);
         reg_rd(A_ST, v);  check($sformatf("R5-9 vec%0d status", k), v, T_ST[k]);
         reg_rd(A_ARG, v); check($sformatf("R5 R6 R7 R8 R9 vec%0d arg0", k), v, T_R0[k]);
         reg_rd(A_ARG + 32'd4, v); check($sformatf("R7 R8 R9 vec%0d arg1", k), v, T_R1[k]);
      end

      // R10 second ID write while busy
      reg_wr(A_ARG, 32'h0);
      reg_wr(A_ST, 32'h0);
      cfg_write(C_IDX, A_ID);
      cfg_write(C_DAT, 32'd2);
      last_w = cyc;
      cfg_write(C_DAT, 32'd1);
      wait_status(d);
      reg_rd(A_ID, v);  check("R10 msg id kept", v, 32'd2);
      reg_rd(A_ARG, v); check("R10 first command result", v, 32'h0006_0002);

      // R12 arg write on completion edge
      run_cmd(32'd1, 32'h100, d);
      reg_wr(A_ARG, 32'h200);
      reg_wr(A_ST, 32'h0);
      cfg_write(C_IDX, A_ID);
      while ((cyc + 1 - last_w) % PER != 0) @(negedge clk);
      cfg_write(C_DAT, 32'd1);
      w2 = cyc;
      cfg_write(C_IDX, A_ARG);
      while (cyc < w2 + d - 1) @(negedge clk);
      cfg_write(C_DAT, 32'h5555);
      reg_rd(A_ARG, v); check("R12 engine wins arg0", v, 32'h201);
      reg_rd(A_ST, v);  check("R12 status after arg collision", v, 32'h01);

      // R12 status clear on completion edge, also checks R4 repeatability
      reg_wr(A_ARG, 32'h300);
      reg_wr(A_ST, 32'h0);
      cfg_write(C_IDX, A_ID);
      last_w = w2;
      while ((cyc + 1 - last_w) % PER != 0) @(negedge clk);
      cfg_write(C_DAT, 32'd1);
      w2 = cyc;
      last_w = w2;
      cfg_write(C_IDX, A_ST);
      while (cyc < w2 + d - 1) @(negedge clk);
      cfg_off = C_DAT;
      #1 check("R4 still pending before predicted edge", cfg_rdata, 32'h0);
      cfg_write(C_DAT, 32'h0);
      d2 = cyc - w2;
      check("R4 repeat delay", 32'(d2), 32'(d));
      cfg_off = C_DAT;
      #1 check("R12 engine wins status", cfg_rdata, 32'h01);
      reg_rd(A_ARG, v); check("R5 after status collision", v, 32'h301);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule